// File: doc/BRIEF.md
# Grouped Match Timer Channels

This block holds eight timer channels, numbered 4 through 11. Each channel has a 32-bit counter, a 32-bit compare value and a control word. The control word selects the tick source that advances the counter and whether the channel compares against its own counter or against the counter that leads its group. It also selects whether a match clears the counter and whether the channel keeps matching after its first hit. Tick sources arrive from outside as single-cycle enable pulses. A counter advances by one on each pulse of the source it has selected.

The channels form groups. Channels 5, 6 and 7 follow channel 4. Channel 9 follows channel 8. Channel 11 follows channel 10. A channel leaves its group when its own-counter bit is set. A match on a channel whose interrupt enable is set raises that channel's status bit. One shared interrupt output stays high while any status bit is set. Channels 9 and 11 can also capture their leader's count into a snapshot register when their own counter is read. Software reaches everything through a simple register port: a write strobe, and a read strobe whose data returns one cycle later with a valid flag.

Top module: `tmr_group`

## Requirements
- R1: After reset, every control, compare, counter, enable, status and snapshot register reads 0 and `irq` is low.
- R2: Register map, all word aligned: counter of channel c at 0x40+4(c-4), compare at 0x80+4(c-4), control at 0xC0+4(c-4), status at 0x14, interrupt enable at 0x1C, snapshot at 0x20. Status and enable use bit c for channel c (bits 11:4). Controls of channels 4-7 hold bits 7:0 and read the upper bits as 0. Controls of channels 8-11 hold bits 9:0.
- R3: Control bits 2:0 select the tick source. Codes 1 to 5 pick `tick_en[code-1]`. Codes 0, 6 and 7 stop the counter. A running counter advances by exactly one per pulse of the selected source and ignores pulses on the other sources.
- R4: With control bit 7 clear, channels 5-7 compare against counter 4, channel 9 against counter 8 and channel 11 against counter 10. With bit 7 set, a channel compares against its own counter.
- R5: The counter of channel 5, 6, 7, 9 or 11 does not count while that channel's bit 7 is clear. On channels 8-11, control bit 8 stops the channel's own counter whatever bits 2:0 hold.
- R6: A match occurs when the followed counter steps onto the channel's compare value while the channel is armed. The match sets status bit c only if enable bit c is set.
- R7: With control bit 3 set, a match loads 0 into the followed counter instead of the incremented value.
- R8: With control bit 6 clear, a channel disarms after it matches. It rearms when its compare register or its followed counter is written. With bit 6 set, the channel stays armed.
- R9: Reading the counter of channel 9 or 11 while that channel's control bit 9 is set copies the current count of channel 8 or 10 into the snapshot register. Without bit 9 set, the read leaves the snapshot unchanged.
- R10: Writing the status register clears each bit that is written as 1. `irq` is high exactly while any status bit is set, and it changes on the same clock edge as the status bits.
- R11: A counter write loads the written value on that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| rd_valid | output | 1 | High in the cycle that `rdata` holds a read result |
| tick_en | input | 5 | Tick source enable pulses, one per source |
| irq | output | 1 | Combined interrupt for channels 4-11 |

## Verification
The bench checks that a follower counts against its leader while its own counter stays frozen. A design that wired the group wrongly would either miss the match or show a moving counter on channel 5. It separates one-shot behaviour from periodic behaviour on a channel that clears its counter on match, so a design that never disarms would report a second status bit. It checks the snapshot in both cases, with and without the capture bit, which catches a copy taken on every read. It checks that `irq` stays high until the last status bit is cleared, which exposes an interrupt dropped on a partial clear. It also checks that bit 8 stops channel 8 and that a disabled interrupt leaves the status untouched.

// File: rtl/tg_pkg.sv
package tg_pkg;
  localparam int NCH   = 8;   // channels 4..11 mapped to index 0..7
  localparam int NSRC  = 5;   // tick sources for select codes 1..5
  localparam int CTRLW = 10;

  // index of the counter that leads the group of channel n
  function automatic int group_lead(input int n);
    if (n < 4)      return 0;
    else if (n < 6) return 4;
    else            return 6;
  endfunction

  function automatic bit is_lead(input int n);
    return (n == group_lead(n));
  endfunction
endpackage

// File: rtl/tg_counter.sv
module tg_counter #(
  parameter int W    = 32,
  parameter int NSRC = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      sel,
  input  logic            run,
  input  logic [NSRC-1:0] tick_en,
  input  logic            ld,
  input  logic [W-1:0]    ld_val,
  input  logic            clr,
  output logic            step,
  output logic [W-1:0]    cnt
);
  logic src_ok;

  always_comb begin
    src_ok = 1'b0;
    for (int s = 1; s <= NSRC; s++)
      if (sel == 3'(s)) src_ok = tick_en[s-1];
  end

  assign step = run && src_ok;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (ld)   cnt <= ld_val;
    else if (step) cnt <= clr ? '0 : cnt + 1'b1;
  end

  // R3: a counter with no step and no load holds its value
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!ld && !step) |=> $stable(cnt));
  // R7: a match with clear-on-match leaves the counter at zero
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (step && clr && !ld) |=> (cnt == '0));
  // R11: a write lands on the next edge
  a_r11_load: assert property (@(posedge clk) disable iff (rst)
    ld |=> (cnt == $past(ld_val)));
endmodule

// File: rtl/tg_match.sv
module tg_match #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt,
  input  logic         step,
  input  logic [W-1:0] cmp,
  input  logic         periodic,
  input  logic         rearm,
  output logic         hit
);
  logic armed;

  assign hit = step && armed && ((cnt + 1'b1) == cmp);

  always_ff @(posedge clk) begin
    if (rst)                    armed <= 1'b1;
    else if (rearm)             armed <= 1'b1;
    else if (hit && !periodic)  armed <= 1'b0;
  end

  // R8: a one-shot channel disarms after its match
  a_r8_disarm: assert property (@(posedge clk) disable iff (rst)
    (hit && !periodic && !rearm) |=> !armed);
  // R8: a rewrite always rearms
  a_r8_rearm: assert property (@(posedge clk) disable iff (rst)
    rearm |=> armed);
endmodule

// File: rtl/tmr_group.sv
module tmr_group #(
  parameter int AW = 8,
  parameter int CW = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [AW-1:0]       addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  output logic                rd_valid,
  input  logic [tg_pkg::NSRC-1:0] tick_en,
  output logic                irq
);
  import tg_pkg::*;

  localparam logic [AW-1:0] A_CNT  = AW'(8'h40);
  localparam logic [AW-1:0] A_CMP  = AW'(8'h80);
  localparam logic [AW-1:0] A_CTL  = AW'(8'hC0);
  localparam logic [AW-1:0] A_STAT = AW'(8'h14);
  localparam logic [AW-1:0] A_IEN  = AW'(8'h1C);
  localparam logic [AW-1:0] A_SNAP = AW'(8'h20);
  localparam int SB = 4;  // status bit of index 0

  logic [CTRLW-1:0] ctrl [NCH];
  logic [CW-1:0]    cmp  [NCH];
  logic [CW-1:0]    cnt  [NCH];
  logic [CW-1:0]    snap_val [NCH];
  logic [2:0]       src  [NCH];
  logic [NCH-1:0]   step, run, clr, hit, rearm, wr_c, wr_m, wr_t, snap_req;
  logic [NCH-1:0]   status, ien, status_nxt, w1c;
  logic [CW-1:0]    snap, rd_mux;

  genvar n;
  generate
    for (n = 0; n < NCH; n++) begin : g_ch
      localparam int LEAD = group_lead(n);
      assign wr_c[n] = wr_en && (addr == A_CNT + AW'(4*n));
      assign wr_m[n] = wr_en && (addr == A_CMP + AW'(4*n));
      assign wr_t[n] = wr_en && (addr == A_CTL + AW'(4*n));
      assign src[n]  = ctrl[n][7] ? 3'(n) : 3'(LEAD);

      if (n >= 4) begin : g_wide
        assign run[n] = (is_lead(n) || ctrl[n][7]) && !ctrl[n][8];
        always_ff @(posedge clk)
          if (rst) ctrl[n] <= '0;
          else if (wr_t[n]) ctrl[n] <= wdata[CTRLW-1:0];
      end else begin : g_narrow
        assign run[n] = is_lead(n) || ctrl[n][7];
        always_ff @(posedge clk)
          if (rst) ctrl[n] <= '0;
          else if (wr_t[n]) ctrl[n] <= {2'b00, wdata[7:0]};
        // R2: narrow controls never hold bits 9:8
        a_r2_narrow: assert property (@(posedge clk) disable iff (rst)
          ctrl[n][9:8] == 2'b00);
      end

      if ((n >= 4) && (n % 2 == 1)) begin : g_snap
        assign snap_req[n] = rd_en && (addr == A_CNT + AW'(4*n)) && ctrl[n][9];
        assign snap_val[n] = cnt[n-1];
        // R9: reading the follower copies the leader's count
        a_r9_snap: assert property (@(posedge clk) disable iff (rst)
          snap_req[n] |=> (snap == $past(cnt[n-1])));
      end else begin : g_nosnap
        assign snap_req[n] = 1'b0;
        assign snap_val[n] = '0;
      end

      always_ff @(posedge clk)
        if (rst) cmp[n] <= '0;
        else if (wr_m[n]) cmp[n] <= wdata;

      tg_counter #(.W(CW), .NSRC(NSRC)) i_cnt (
        .clk(clk), .rst(rst), .sel(ctrl[n][2:0]), .run(run[n]),
        .tick_en(tick_en), .ld(wr_c[n]), .ld_val(wdata), .clr(clr[n]),
        .step(step[n]), .cnt(cnt[n])
      );

      assign rearm[n] = wr_m[n] || wr_c[src[n]];

      tg_match #(.W(CW)) i_match (
        .clk(clk), .rst(rst), .cnt(cnt[src[n]]), .step(step[src[n]]),
        .cmp(cmp[n]), .periodic(ctrl[n][6]), .rearm(rearm[n]), .hit(hit[n])
      );
    end
  endgenerate

  // clear-on-match from any follower of counter k
  always_comb begin
    clr = '0;
    for (int k = 0; k < NCH; k++)
      for (int j = 0; j < NCH; j++)
        if (hit[j] && ctrl[j][3] && (src[j] == 3'(k))) clr[k] = 1'b1;
  end

  assign w1c        = (wr_en && addr == A_STAT) ? wdata[SB+NCH-1:SB] : '0;
  assign status_nxt = (status & ~w1c) | (hit & ien);

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      ien    <= '0;
      irq    <= 1'b0;
      snap   <= '0;
    end else begin
      status <= status_nxt;
      irq    <= |status_nxt;
      if (wr_en && addr == A_IEN) ien <= wdata[SB+NCH-1:SB];
      for (int k = 0; k < NCH; k++)
        if (snap_req[k]) snap <= snap_val[k];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr[1:0] == 2'b00) begin
      case (addr[AW-1:5])
        3'b010: rd_mux = cnt[addr[4:2]];
        3'b100: rd_mux = cmp[addr[4:2]];
        3'b110: rd_mux = CW'(ctrl[addr[4:2]]);
        default: begin
          if (addr == A_STAT) rd_mux = CW'({status, 4'h0});
          if (addr == A_IEN)  rd_mux = CW'({ien, 4'h0});
          if (addr == A_SNAP) rd_mux = snap;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end

  // R10: the interrupt mirrors the status bits
  a_r10_irq: assert property (@(posedge clk) disable iff (rst)
    irq == (|status));
  // R6: a status bit only rises on an enabled match
  a_r6_set: assert property (@(posedge clk) disable iff (rst)
    (|(~status & status_nxt)) |-> (|(hit & ien)));
endmodule

// File: tb/test_tmr_group.sv
module test_tmr_group;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rd_valid;
  logic [4:0]  tick_en = '0;
  logic        irq;

  int checks = 0, errors = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  tmr_group i_tmr_group (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
    .tick_en(tick_en), .irq(irq)
  );

  // monitor: pops the scoreboard when a read result appears
  always @(negedge clk) begin
    if (rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read data %h expected none", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic tick(input int s, input int num);
    for (int i = 0; i < num; i++) begin
      tick_en = 5'(1 << (s - 1));
      @(negedge clk);
      tick_en = '0;
    end
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s irq actual %b expected %b", t, irq, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    rd(8'hC0, 0, "R1 ctrl4");
    rd(8'h40, 0, "R1 cnt4");
    rd(8'h20, 0, "R1 snapshot");
    rd(8'h14, 0, "R1 status");
    chk_irq(1'b0, "R1");
    // R2 control widths
    wr(8'hC4, 32'hFFFF_FFFF); rd(8'hC4, 32'hFF, "R2 ctrl5 width");
    wr(8'hD0, 32'hFFFF_FFFF); rd(8'hD0, 32'h3FF, "R2 ctrl8 width");
    wr(8'hC4, 0); wr(8'hD0, 0);
    // R3 tick selection
    wr(8'hC0, 32'h01); tick(1, 3); rd(8'h40, 3, "R3 code1");
    tick(2, 2); rd(8'h40, 3, "R3 other source ignored");
    wr(8'hC0, 32'h06); tick(1, 1); rd(8'h40, 3, "R3 code6 stopped");
    wr(8'hC0, 32'h02); tick(2, 2); rd(8'h40, 5, "R3 code2");
    wr(8'hC0, 32'h05); tick(5, 1); rd(8'h40, 6, "R3 code5");
    // R11 load
    wr(8'h40, 0); rd(8'h40, 0, "R11 counter write");
    // R4/R5/R6 grouping and match
    wr(8'hC0, 32'h01); wr(8'h1C, 32'hFF0);
    wr(8'hC4, 32'h01); wr(8'h84, 4);
    tick(1, 3); chk_irq(1'b0, "R6 before match");
    tick(1, 1); chk_irq(1'b1, "R4 follower match");
    rd(8'h14, 32'h20, "R6 status bit5");
    rd(8'h44, 0, "R5 follower counter frozen");
    // R10 W1C
    wr(8'h14, 32'h10); chk_irq(1'b1, "R10 partial clear");
    rd(8'h14, 32'h20, "R10 status kept");
    wr(8'h14, 32'h20); chk_irq(1'b0, "R10 full clear");
    // R8 rearm by counter write
    wr(8'h40, 3); tick(1, 1); rd(8'h14, 32'h20, "R8 rearm by counter write");
    wr(8'h14, 32'hFF0);
    wr(8'hC0, 0); wr(8'hC4, 0);
    // R7 / R8 one-shot on ch6 with own counter
    wr(8'hC8, 32'h89); wr(8'h88, 2); wr(8'h48, 0);
    tick(1, 2); rd(8'h14, 32'h40, "R6 ch6 match");
    rd(8'h48, 0, "R7 clear on match");
    wr(8'h14, 32'h40);
    tick(1, 2); rd(8'h14, 0, "R8 one-shot no second match");
    rd(8'h48, 2, "R8 counter ran on");
    // R8 periodic
    wr(8'hC8, 32'hC9); wr(8'h88, 2); wr(8'h48, 0);
    tick(1, 2); wr(8'h14, 32'h40);
    tick(1, 2); rd(8'h14, 32'h40, "R8 periodic second match");
    wr(8'h14, 32'hFF0); wr(8'hC8, 0);
    // R5 bit8 stops ch8
    wr(8'hD0, 32'h101); wr(8'h50, 0); tick(1, 2);
    rd(8'h50, 0, "R5 bit8 stop");
    wr(8'hD0, 32'h001); tick(1, 3); rd(8'h50, 3, "R3 ch8 counts");
    // R9 snapshot
    wr(8'hD4, 32'h200); rd(8'h54, 0, "R5 ch9 own frozen");
    rd(8'h20, 3, "R9 snapshot of ch8");
    wr(8'hDC, 0); wr(8'hD8, 32'h001); tick(1, 2);
    rd(8'h5C, 0, "R9 ch11 read"); rd(8'h20, 3, "R9 no capture without bit9");
    wr(8'hDC, 32'h200); rd(8'h5C, 0, "R9 ch11 read");
    rd(8'h20, 2, "R9 snapshot of ch10");
    // R4 ch9 follows ch8
    wr(8'hD4, 0); wr(8'h94, 7); tick(1, 2);
    rd(8'h14, 32'h200, "R4 ch9 follows ch8");
    wr(8'h14, 32'h200);
    // R6 disabled interrupt, R4 own counter
    wr(8'h1C, 0); wr(8'hCC, 32'h81); wr(8'h8C, 1); wr(8'h4C, 0);
    tick(1, 1); rd(8'h14, 0, "R6 disabled no status");
    chk_irq(1'b0, "R6 disabled no irq");
    rd(8'h4C, 1, "R4 own counter ch7");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard actual %0d pending expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule